// File: doc/BRIEF.md
# Pipelined Two-Level Memory Read

This block holds 256 bytes as eight wide rows of 32 bytes and serves 32-bit reads from them through a two-stage pipeline. An 8-bit byte address is split into a row index (bits 7:5) and a word index within that row (bits 4:2). The first stage decodes the row index with a 3-to-8 decoder and registers the whole 256-bit row together with the word index. The second stage picks one 32-bit word out of that registered row and registers it. A read can therefore be issued on every clock cycle, and its data returns at a fixed latency of two cycles.

A valid flag travels with each read, and the returned word counts only when the output valid is high. A plain synchronous write port loads the array one aligned word at a time. Reset flushes the reads in flight but leaves the stored bytes alone.

Top module: `mrd_pipe_read`

## Requirements
- R1: While reset is high, and after it until a read has been issued and has come through, `rd_valid` is 0. A reset flushes any reads that are in flight.
- R2: A read issued with `rd_en` high at a rising edge shows `rd_valid` = 1 right after the second rising edge that follows it, and `rd_valid` is 1 exactly then. A cycle with `rd_en` low gives `rd_valid` = 0 two edges later.
- R3: Reads issued on consecutive cycles come back on consecutive cycles, in issue order, with no gap.
- R4: A read returns the 32-bit word stored at word address `rd_addr[7:2]`. Row `rd_addr[7:5]` is one of eight 256-bit rows, and `rd_addr[4:2]` picks the word within it.
- R5: `rd_addr[1:0]` has no effect on a read: all four byte offsets return the same aligned word.
- R6: With `wr_en` high at a rising edge, `wr_data` is stored at word address `wr_addr[7:2]`. `wr_addr[1:0]` is ignored.
- R7: A read and a write to the same word at the same edge make the read return the old word. A later read returns the new word.
- R8: Reset leaves the stored words unchanged. Reads after reset return what was written before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the pipeline valid flags |
| rd_en | input | 1 | Issue a read this cycle |
| rd_addr | input | 8 | Byte address of the read |
| wr_en | input | 1 | Store `wr_data` this cycle |
| wr_addr | input | 8 | Byte address of the write; low two bits ignored |
| wr_data | input | 32 | Word to store |
| rd_valid | output | 1 | Read data on `rd_data` is valid |
| rd_data | output | 32 | Word returned two cycles after issue |

## Verification
The bench fills every word, then reads all 64 back to back in reverse order. A design that mixed up the row bits with the word bits, or that let a stage stall or drop a read, would return wrong words or show a gap in the valid stream. It reads one word at every byte offset, which catches an address decode that uses bits 1:0. It issues a write and a read to the same word at the same edge, which exposes a write-through that returns the new word too early. It asserts reset with reads in flight and then reads the whole array back. A design that left a valid set, or that cleared the storage, fails there.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    localparam int ADDR_W     = 8;
    localparam int WORD_W     = 32;
    localparam int ROW_WORDS  = 8;
    localparam int N_ROWS     = 8;

    localparam int BYTE_OFS_W = $clog2(WORD_W / 8);
    localparam int WSEL_W     = $clog2(ROW_WORDS);
    localparam int RSEL_W     = $clog2(N_ROWS);
    localparam int ROW_W      = WORD_W * ROW_WORDS;
    localparam int WADDR_W    = RSEL_W + WSEL_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic              valid;
        logic [WSEL_W-1:0] wsel;
        row_t              row;
    } stage1_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } stage2_t;

    function automatic logic [RSEL_W-1:0] row_of(input addr_t a);
        return a[ADDR_W-1 -: RSEL_W];
    endfunction

    function automatic logic [WSEL_W-1:0] word_of(input addr_t a);
        return a[BYTE_OFS_W +: WSEL_W];
    endfunction

endpackage

// File: rtl/mrd_decoder.sv
module mrd_decoder #(
    parameter int N     = 8,
    parameter int SEL_W = $clog2(N)
) (
    input  logic [SEL_W-1:0] sel,
    output logic [N-1:0]     hot
);
    always_comb begin
        hot = '0;
        for (int i = 0; i < N; i++) begin
            if (sel == SEL_W'(i)) hot[i] = 1'b1;
        end
    end
endmodule

// File: rtl/mrd_row_array.sv
module mrd_row_array #(
    parameter int N_ROWS    = 8,
    parameter int ROW_WORDS = 8,
    parameter int WORD_W    = 32,
    parameter int ROW_W     = WORD_W * ROW_WORDS,
    parameter int RSEL_W    = $clog2(N_ROWS),
    parameter int WSEL_W    = $clog2(ROW_WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [RSEL_W-1:0] wr_row,
    input  logic [WSEL_W-1:0] wr_wsel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [RSEL_W-1:0] rd_row,
    output logic [ROW_W-1:0]  rd_row_data
);
    logic [N_ROWS-1:0] wr_hot;
    logic [N_ROWS-1:0] rd_hot;
    logic [ROW_W-1:0]  masked [N_ROWS];

    mrd_decoder #(.N(N_ROWS), .SEL_W(RSEL_W)) u_wr_dec (.sel(wr_row), .hot(wr_hot));
    mrd_decoder #(.N(N_ROWS), .SEL_W(RSEL_W)) u_rd_dec (.sel(rd_row), .hot(rd_hot));

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        logic [ROW_W-1:0] row_q;

        for (genvar w = 0; w < ROW_WORDS; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (wr_en && wr_hot[r] && (wr_wsel == WSEL_W'(w))) begin
                    row_q[w*WORD_W +: WORD_W] <= wr_data;
                end
            end
        end

        assign masked[r] = rd_hot[r] ? row_q : '0;
    end

    always_comb begin
        rd_row_data = '0;
        for (int r = 0; r < N_ROWS; r++) begin
            rd_row_data = rd_row_data | masked[r];
        end
    end
endmodule

// File: rtl/mrd_word_sel.sv
module mrd_word_sel #(
    parameter int ROW_WORDS = 8,
    parameter int WORD_W    = 32,
    parameter int ROW_W     = WORD_W * ROW_WORDS,
    parameter int WSEL_W    = $clog2(ROW_WORDS)
) (
    input  logic [ROW_W-1:0]  row,
    input  logic [WSEL_W-1:0] wsel,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = '0;
        for (int i = 0; i < ROW_WORDS; i++) begin
            if (wsel == WSEL_W'(i)) word = row[i*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/mrd_pipe_read.sv
module mrd_pipe_read
    import mrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    row_t    row_now;
    word_t   word_pick;
    stage1_t s1_q;
    stage2_t s2_q;

    mrd_row_array #(
        .N_ROWS(N_ROWS), .ROW_WORDS(ROW_WORDS), .WORD_W(WORD_W)
    ) u_array (
        .clk        (clk),
        .wr_en      (wr_en),
        .wr_row     (row_of(wr_addr)),
        .wr_wsel    (word_of(wr_addr)),
        .wr_data    (wr_data),
        .rd_row     (row_of(rd_addr)),
        .rd_row_data(row_now)
    );

    // Stage 1: whole row plus word index
    always_ff @(posedge clk) begin
        s1_q.row  <= row_now;
        s1_q.wsel <= word_of(rd_addr);
        if (rst) s1_q.valid <= 1'b0;
        else     s1_q.valid <= rd_en;
    end

    mrd_word_sel #(.ROW_WORDS(ROW_WORDS), .WORD_W(WORD_W)) u_sel (
        .row (s1_q.row),
        .wsel(s1_q.wsel),
        .word(word_pick)
    );

    // Stage 2: selected word
    always_ff @(posedge clk) begin
        s2_q.data <= word_pick;
        if (rst) s2_q.valid <= 1'b0;
        else     s2_q.valid <= s1_q.valid;
    end

    assign rd_valid = s2_q.valid;
    assign rd_data  = s2_q.data;
endmodule

// File: rtl/mrd_pipe_read_chk.sv
module mrd_pipe_read_chk
    import mrd_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    rd_en,
    input logic    rd_valid,
    input stage1_t s1
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_FLUSH: assert property (@(posedge clk)
        rst |=> !rd_valid);                                           // R1

    AST_VALID_KNOWN: assert property (@(posedge clk)
        !$isunknown(rd_valid));                                       // R1

    AST_STAGE1_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1) |-> (s1.valid == $past(rd_en)));          // R2

    AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (rd_valid == $past(rd_en, 2)));       // R2

    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && $past(rd_en, 2) && $past(rd_en, 3))
            |-> (rd_valid && $past(rd_valid)));                       // R3
endmodule

bind mrd_pipe_read mrd_pipe_read_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_valid(rd_valid),
    .s1      (s1_q)
);

// File: tb/mrd_pipe_read_test.sv
module mrd_pipe_read_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        rd_en;
    logic [7:0]  rd_addr;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic        rd_valid;
    logic [31:0] rd_data;

    int    n_chk  = 0;
    int    n_fail = 0;
    string tag    = "R1";

    // Behavioural reference: word memory plus two-slot delay line
    logic [31:0] ref_mem [64];
    logic        m_v1 = 1'b0, m_v2 = 1'b0;
    logic [31:0] m_d1 = '0,   m_d2 = '0;

    always #5 clk = ~clk;

    mrd_pipe_read uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_v1 = 1'b0;
            m_v2 = 1'b0;
        end else begin
            m_v2 = m_v1;
            m_d2 = m_d1;
            m_v1 = rd_en;
            m_d1 = ref_mem[rd_addr[7:2]];
        end
        if (wr_en) ref_mem[wr_addr[7:2]] = wr_data;
    end

    function automatic logic [31:0] pat(input int i, input int salt);
        return (32'h9E3779B9 * 32'(i + 1)) ^ (32'(i) << 24) ^ 32'(salt);
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Check at the falling edge, against the model, on every cycle
    task automatic cycle();
        @(negedge clk);
        n_chk++;
        if (rd_valid !== m_v2 || (m_v2 && rd_data !== m_d2)) begin
            n_fail++;
            $display("FAIL %s: rd_valid=%0b rd_data=%h expected valid=%0b data=%h",
                     tag, rd_valid, rd_data, m_v2, m_d2);
        end
    endtask

    task automatic idle();
        rd_en = 1'b0; wr_en = 1'b0;
        cycle();
    endtask

    task automatic rd(input logic [7:0] a);
        rd_en = 1'b1; rd_addr = a; wr_en = 1'b0;
        cycle();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
        $finish;
    end

    initial begin
        rst = 1'b1; rd_en = 1'b1; rd_addr = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;

        // R1: reset state, even with rd_en high
        tag = "R1";
        repeat (3) cycle();
        n_chk++;
        if (rd_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: rd_valid=%0b expected 0 in reset", rd_valid);
        end
        rd_en = 1'b0;
        cycle();
        rst = 1'b0;
        repeat (3) idle();

        // R6: fill every word, low address bits set to junk
        tag = "R6";
        for (int i = 0; i < 64; i++) begin
            wr_en = 1'b1; rd_en = 1'b0;
            wr_addr = {i[5:0], 2'(i % 4)};
            wr_data = pat(i, 0);
            cycle();
        end
        idle();

        // R2: lone read, then bubbles
        tag = "R2";
        rd(8'h44);
        repeat (4) idle();
        rd(8'hE0);
        idle();
        rd(8'h1C);
        repeat (3) idle();

        // R3 and R4: every word back to back, reverse order
        tag = "R3";
        for (int i = 63; i >= 0; i--) rd({i[5:0], 2'b00});
        tag = "R4";
        repeat (3) idle();
        for (int i = 0; i < 64; i += 9) rd({i[5:0], 2'b00});
        repeat (3) idle();

        // R5: byte offset ignored
        tag = "R5";
        for (int k = 0; k < 4; k++) rd({6'd37, 2'(k)});
        for (int k = 3; k >= 0; k--) rd({6'd2, 2'(k)});
        repeat (3) idle();

        // R7: read and write same word at same edge
        tag = "R7";
        rd_en = 1'b1; rd_addr = 8'h2A;
        wr_en = 1'b1; wr_addr = 8'h29; wr_data = 32'hC0FFEE01;
        cycle();
        idle();
        idle();
        rd(8'h28);
        rd_en = 1'b1; rd_addr = 8'h28;
        wr_en = 1'b1; wr_addr = 8'h28; wr_data = 32'h0BADF00D;
        cycle();
        rd(8'h28);
        repeat (3) idle();

        // R8 with R1: reset while reads are in flight
        tag = "R8";
        rd(8'h10);
        rd(8'h14);
        rst = 1'b1; rd_en = 1'b1; rd_addr = 8'h18;
        cycle();
        cycle();
        rst = 1'b0; rd_en = 1'b0;
        tag = "R1";
        repeat (3) idle();
        tag = "R8";
        for (int i = 0; i < 64; i++) rd({i[5:0], 2'b11});
        repeat (3) idle();

        report();
        $finish;
    end
endmodule